// File: doc/BRIEF.md
# Intensity-Weighted Edge-Preserving Smoother

This block is a pipelined 3×3 smoothing filter for 8-bit pixels. Each cycle in which `in_valid` is high, it takes one window of nine pixels and one flag. The flag marks whether the centre pixel sits on an edge. Every neighbour is weighted by how close its intensity is to the centre. The weight is the complement of the absolute difference, raised to the eighth power by three squarings, and each squaring keeps only the upper eight bits of a 16-bit product. The result is the weighted mean of the window: the sum of weight·pixel divided by the sum of weights, rounded down. Pixels that differ strongly from the centre therefore barely contribute, so smoothing runs along edges and not across them.

Only centre pixels flagged as edge pixels receive the filtered value. All others leave the block unchanged. The same fixed latency applies in both cases, so a raster stream stays in order. Forming the windows upstream and computing the edge flag are the surrounding design's job.

Top module: `ep_filter`

## Requirements
- R1: While reset is held and after its release, before any window has been accepted, `valid_out` is 0 and `pix_out` is 0.
- R2: A window accepted with `ez_in` = 0 produces its centre pixel x5 (bits 39:32 of `win_in`) unchanged, whatever the neighbours hold.
- R3: A window accepted with `ez_in` = 1 in which all nine pixels are equal produces that same value (unity gain).
- R4: For `ez_in` = 1, with tap xi in bits [8(i−1)+7 : 8(i−1)] for i = 1..9, let t = 255 − |xi − x5|. Apply t ← floor(t·t/256) three times to get ci. The output is floor(Σ ci·xi / Σ ci).
- R5: Each window accepted at a rising edge appears on `pix_out` with `valid_out` high exactly 12 rising edges later, counting the accepting edge as the first. Each accepted window yields exactly one `valid_out` cycle.
- R6: Windows accepted on consecutive cycles give results on consecutive cycles, in acceptance order.
- R7: The filtered result always lies between the smallest and the largest pixel of its window. The divider never needs saturation.
- R8: A neighbour whose distance from the centre is 255 gets zero weight. A black centre among white neighbours therefore stays 0, and a white centre among black neighbours stays 255.
- R9: While `in_valid` is 0, the window and flag inputs are ignored: no `valid_out` results from them, and `pix_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window and flag are taken this cycle |
| win_in | input | 72 | Nine 8-bit taps; x1 in bits 7:0, centre x5 in bits 39:32, x9 in bits 71:64 |
| ez_in | input | 1 | 1 = centre is an edge pixel and is filtered; 0 = centre passes through |
| valid_out | output | 1 | `pix_out` carries a new result |
| pix_out | output | 8 | Result pixel, held between results |

## Verification
Flat windows separate a gain error from a weighting error: any correct weighting must return the input level. Black/white windows test the zero-weight end of the curve, where a complement or truncation slip would leak a neighbour into the result. Random windows with the flag clear test the bypass path. Random windows with the flag set, with both narrow and full intensity spread, compare the exact truncated arithmetic against an independent model and check that the result stays within the window's range. A long back-to-back burst and an idle stretch carrying garbage windows check ordering, exact latency, and that unaccepted inputs leave no trace.

// File: rtl/epf_pkg.sv
package epf_pkg;
  localparam int PIX_W    = 8;
  localparam int TAPS     = 9;
  localparam int CTR      = 4;
  localparam int SUM_GROW = $clog2(TAPS);
  localparam int NUM_W    = 2 * PIX_W + SUM_GROW;
  localparam int DEN_W    = PIX_W + SUM_GROW;

  typedef logic [PIX_W-1:0]              pix_t;
  typedef logic [TAPS-1:0][PIX_W-1:0]    win_t;
  typedef logic [2*PIX_W-1:0]            prod_t;

  localparam pix_t PIX_MAX = '1;

  function automatic pix_t pix_dist(input pix_t a, input pix_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic pix_t closeness(input pix_t d);
    return PIX_MAX - d;
  endfunction

  function automatic pix_t trunc_sq(input pix_t t);
    prod_t p;
    p = prod_t'(t) * prod_t'(t);
    return p[2*PIX_W-1:PIX_W];
  endfunction

  function automatic win_t trunc_sq_all(input win_t v);
    win_t r;
    for (int i = 0; i < TAPS; i++) r[i] = trunc_sq(v[i]);
    return r;
  endfunction
endpackage

// File: rtl/ep_weight_gen.sv
module ep_weight_gen
  import epf_pkg::*;
#(
  parameter int POW_STEPS = 3
) (
  input  logic clk,
  input  win_t win_i,
  output win_t wgt_o,
  output win_t win_o
);
  localparam int DEPTH = 2 + POW_STEPS;

  win_t dist_c;
  win_t dist_q;
  win_t cmp_q;
  win_t pw_q  [POW_STEPS];
  win_t win_q [DEPTH];

  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign dist_c[i] = pix_dist(win_i[i], win_i[CTR]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    dist_q <= dist_c;
    for (int i = 0; i < TAPS; i++) cmp_q[i] <= closeness(dist_q[i]);
    pw_q[0] <= trunc_sq_all(cmp_q);
    for (int s = 1; s < POW_STEPS; s++) pw_q[s] <= trunc_sq_all(pw_q[s-1]);
    win_q[0] <= win_i;
    for (int k = 1; k < DEPTH; k++) win_q[k] <= win_q[k-1];
  end

  assign wgt_o = pw_q[POW_STEPS-1];
  assign win_o = win_q[DEPTH-1];
endmodule

// File: rtl/ep_accum.sv
module ep_accum
  import epf_pkg::*;
(
  input  logic             clk,
  input  win_t             wgt_i,
  input  win_t             win_i,
  output logic [NUM_W-1:0] num_o,
  output logic [DEN_W-1:0] den_o
);
  prod_t prod_c [TAPS];
  prod_t prod_q [TAPS];
  win_t  wgt_q;
  logic [NUM_W-1:0] num_c;
  logic [DEN_W-1:0] den_c;

  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_mul
      assign prod_c[i] = prod_t'(wgt_i[i]) * prod_t'(win_i[i]);
    end
  endgenerate

  always_comb begin
    num_c = '0;
    den_c = '0;
    for (int i = 0; i < TAPS; i++) begin
      num_c = num_c + NUM_W'(prod_q[i]);
      den_c = den_c + DEN_W'(wgt_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < TAPS; i++) prod_q[i] <= prod_c[i];
    wgt_q <= wgt_i;
    num_o <= num_c;
    den_o <= den_c;
  end
endmodule

// File: rtl/ep_divider.sv
module ep_divider
  import epf_pkg::*;
#(
  parameter int STEP = 2
) (
  input  logic             clk,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output pix_t             quo_o,
  output logic [NUM_W-1:0] rem_o,
  output logic [DEN_W-1:0] den_o
);
  localparam int NSTG = PIX_W / STEP;

  logic [NUM_W-1:0] rem_q [NSTG];
  logic [DEN_W-1:0] den_q [NSTG];
  pix_t             quo_q [NSTG];
  logic [NUM_W-1:0] rem_n [NSTG];
  logic [DEN_W-1:0] den_n [NSTG];
  pix_t             quo_n [NSTG];

  always_comb begin
    logic [NUM_W-1:0] r;
    logic [NUM_W-1:0] trial;
    logic [DEN_W-1:0] d;
    pix_t             q;
    int               pos;
    for (int s = 0; s < NSTG; s++) begin
      r = (s == 0) ? num_i : rem_q[(s == 0) ? 0 : s-1];
      d = (s == 0) ? den_i : den_q[(s == 0) ? 0 : s-1];
      q = (s == 0) ? '0    : quo_q[(s == 0) ? 0 : s-1];
      for (int b = 0; b < STEP; b++) begin
        pos   = PIX_W - 1 - (s * STEP + b);
        trial = NUM_W'(d) << pos;
        if (r >= trial) begin
          r      = r - trial;
          q[pos] = 1'b1;
        end
      end
      rem_n[s] = r;
      den_n[s] = d;
      quo_n[s] = q;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTG; s++) begin
      rem_q[s] <= rem_n[s];
      den_q[s] <= den_n[s];
      quo_q[s] <= quo_n[s];
    end
  end

  assign quo_o = quo_q[NSTG-1];
  assign rem_o = rem_q[NSTG-1];
  assign den_o = den_q[NSTG-1];
endmodule

// File: rtl/ep_filter.sv
module ep_filter
  import epf_pkg::*;
#(
  parameter int POW_STEPS = 3,
  parameter int DIV_STEP  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [TAPS*PIX_W-1:0] win_in,
  input  logic                  ez_in,
  output logic                  valid_out,
  output logic [PIX_W-1:0]      pix_out
);
  localparam int WG_DEPTH   = 2 + POW_STEPS;
  localparam int ACC_DEPTH  = 2;
  localparam int DIV_DEPTH  = PIX_W / DIV_STEP;
  localparam int CORE_DEPTH = WG_DEPTH + ACC_DEPTH + DIV_DEPTH;
  localparam int LATENCY    = CORE_DEPTH + 1;

  win_t             win_w;
  win_t             wgt_w;
  win_t             win_d;
  logic [NUM_W-1:0] acc_num;
  logic [DEN_W-1:0] acc_den;
  pix_t             div_quo;
  logic [NUM_W-1:0] div_rem;
  logic [DEN_W-1:0] div_den;

  logic vld_q [CORE_DEPTH];
  logic ez_q  [CORE_DEPTH];
  pix_t x5_q  [CORE_DEPTH];

  logic acc_vld;
  logic div_vld;
  logic div_over;
  pix_t filt_pix;

  assign win_w = win_t'(win_in);

  ep_weight_gen #(.POW_STEPS(POW_STEPS)) u_wgen (
    .clk   (clk),
    .win_i (win_w),
    .wgt_o (wgt_w),
    .win_o (win_d)
  );

  ep_accum u_acc (
    .clk   (clk),
    .wgt_i (wgt_w),
    .win_i (win_d),
    .num_o (acc_num),
    .den_o (acc_den)
  );

  ep_divider #(.STEP(DIV_STEP)) u_div (
    .clk   (clk),
    .num_i (acc_num),
    .den_i (acc_den),
    .quo_o (div_quo),
    .rem_o (div_rem),
    .den_o (div_den)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CORE_DEPTH; k++) vld_q[k] <= 1'b0;
    end else begin
      vld_q[0] <= in_valid;
      for (int k = 1; k < CORE_DEPTH; k++) vld_q[k] <= vld_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    ez_q[0] <= ez_in;
    x5_q[0] <= win_w[CTR];
    for (int k = 1; k < CORE_DEPTH; k++) begin
      ez_q[k] <= ez_q[k-1];
      x5_q[k] <= x5_q[k-1];
    end
  end

  assign acc_vld  = vld_q[WG_DEPTH + ACC_DEPTH - 1];
  assign div_vld  = vld_q[CORE_DEPTH-1];
  assign div_over = (div_rem >= NUM_W'(div_den));
  assign filt_pix = div_over ? PIX_MAX : div_quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      pix_out   <= '0;
    end else begin
      valid_out <= div_vld;
      if (div_vld) pix_out <= ez_q[CORE_DEPTH-1] ? filt_pix : x5_q[CORE_DEPTH-1];
    end
  end
endmodule

// File: rtl/epf_checks.sv
module epf_checks
  import epf_pkg::*;
#(
  parameter int LAT = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             valid_out,
  input logic [PIX_W-1:0] pix_out,
  input logic             acc_vld,
  input logic [DEN_W-1:0] acc_den,
  input logic             div_vld,
  input logic [NUM_W-1:0] div_rem,
  input logic [DEN_W-1:0] div_den
);
  logic [7:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + 8'(in_valid) - 8'(valid_out);
  end

  // Weight sum reaching the divider is never zero (centre weight is positive)
  assert_den_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> (acc_den != '0));

  // Quotient fits the pixel range: the remainder ends below the divisor
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_vld |-> (div_rem < NUM_W'(div_den)));

  // Every output corresponds to an accepted window
  assert_no_orphan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (inflight != 8'd0));

  // No more windows in flight than pipeline stages
  assert_inflight_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inflight) <= LAT);

  // Result is held between outputs
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> $stable(pix_out));
endmodule

bind ep_filter epf_checks #(.LAT(LATENCY)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .valid_out (valid_out),
  .pix_out   (pix_out),
  .acc_vld   (acc_vld),
  .acc_den   (acc_den),
  .div_vld   (div_vld),
  .div_rem   (div_rem),
  .div_den   (div_den)
);

// File: tb/tb_ep_filter.sv
`timescale 1ns/1ps
module tb_ep_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [71:0] win_in = '0;
  logic        ez_in = 1'b0;
  logic        valid_out;
  logic [7:0]  pix_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int    due;
    int    val;
    int    lo;
    int    hi;
    bit    filt;
    string req;
  } item_t;

  item_t sb[$];

  ep_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_in(win_in),
    .ez_in(ez_in), .valid_out(valid_out), .pix_out(pix_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int tap(input logic [71:0] w, input int i);
    return int'(w[8*i +: 8]);
  endfunction

  // Independent model of the weighted mean
  function automatic int model(input logic [71:0] w, input bit e);
    int c, num, den, ctr;
    ctr = tap(w, 4);
    if (!e) return ctr;
    num = 0; den = 0;
    for (int i = 0; i < 9; i++) begin
      c = 255 - ((tap(w, i) > ctr) ? tap(w, i) - ctr : ctr - tap(w, i));
      for (int k = 0; k < 3; k++) c = (c * c) / 256;
      num += c * tap(w, i);
      den += c;
    end
    return num / den;
  endfunction

  task automatic send(input logic [71:0] w, input bit e, input string req);
    item_t it;
    int lo, hi;
    @(negedge clk);
    win_in = w; ez_in = e; in_valid = 1'b1;
    lo = 255; hi = 0;
    for (int i = 0; i < 9; i++) begin
      if (tap(w, i) < lo) lo = tap(w, i);
      if (tap(w, i) > hi) hi = tap(w, i);
    end
    it.due = cyc + 12; it.val = model(w, e); it.lo = lo; it.hi = hi;
    it.filt = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [71:0] flat(input logic [7:0] v);
    return {9{v}};
  endfunction

  function automatic logic [71:0] rnd_win();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [71:0] near_win(input int base);
    logic [71:0] w;
    int v;
    for (int i = 0; i < 9; i++) begin
      v = base + int'($urandom_range(0, 40)) - 20;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      w[8*i +: 8] = 8'(v);
    end
    return w;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    item_t it;
    if (rst_n && !finished) begin
      if (valid_out) begin
        if (sb.size() == 0) begin
          check(1'b0, "R5 unexpected output", int'(pix_out), -1);
        end else begin
          it = sb.pop_front();
          check(int'(pix_out) == it.val, it.req, int'(pix_out), it.val);
          check(cyc == it.due, "R5 latency", cyc, it.due);
          if (it.filt)
            check(int'(pix_out) >= it.lo && int'(pix_out) <= it.hi, "R7 range",
                  int'(pix_out), it.lo);
        end
      end else if (sb.size() != 0 && sb[0].due == cyc) begin
        check(1'b0, "R5 missing output", 0, sb[0].val);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(valid_out == 1'b0, "R1 valid in reset", int'(valid_out), 0);
    check(pix_out == 8'd0, "R1 pixel in reset", int'(pix_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(valid_out == 1'b0, "R1 valid after reset", int'(valid_out), 0);
    check(pix_out == 8'd0, "R1 pixel after reset", int'(pix_out), 0);

    // R2: bypass of non-edge pixels
    for (int n = 0; n < 12; n++) send(rnd_win(), 1'b0, "R2 bypass");
    // R3: flat windows keep their level
    send(flat(8'd0), 1'b1, "R3 flat 0");
    send(flat(8'd128), 1'b1, "R3 flat 128");
    send(flat(8'd200), 1'b1, "R3 flat 200");
    send(flat(8'd255), 1'b1, "R3 flat 255");
    idle(4);
    // R8: far neighbours get zero weight
    send({{4{8'hFF}}, 8'h00, {4{8'hFF}}}, 1'b1, "R8 black centre");
    send({{4{8'h00}}, 8'hFF, {4{8'h00}}}, 1'b1, "R8 white centre");
    idle(3);
    // R4: exact weighted mean, narrow and full spread
    for (int n = 0; n < 25; n++) send(near_win(int'($urandom_range(0, 255))), 1'b1, "R4 narrow");
    for (int n = 0; n < 25; n++) send(rnd_win(), 1'b1, "R4 full");
    idle(15);
    // R6: long burst mixing both paths
    for (int n = 0; n < 40; n++) send(rnd_win(), 1'(n % 2), "R6 burst");
    idle(16);
    // R9: inputs ignored while not valid
    held = pix_out;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      in_valid = 1'b0; win_in = rnd_win(); ez_in = 1'(n % 2);
      check(valid_out == 1'b0, "R9 no output when idle", int'(valid_out), 0);
      check(pix_out == held, "R9 pixel held", int'(pix_out), int'(held));
    end
    idle(14);
    check(sb.size() == 0, "R5 outstanding results", sb.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule